// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits in front of a paged memory write controller and inspects every qualified write strobe before it reaches the page buffer. It recognises fixed-address command sequences that turn a persistent software write-protect flag on or off, marks command bytes so they are never stored, and tells the controller whether each remaining data byte may reach the array. When protection is active, a plain write is blocked, but the controller is still asked to run a timed cycle so that software sees the normal busy period.

A load window opens with each strobe and closes after `GAP_CYCLES` clock cycles with no further strobe. That is the byte-load timeout. If a window held no byte that passed but did hold a blocked byte or a complete command sequence, the block pulses a dummy-cycle request as the window closes. A change of protection does not take effect when its sequence ends. It waits in an armed state and is applied only when the controller reports that the next timed write cycle has ended. The flag has its own power-on default input. The ordinary reset does not clear it.

Top module: `wp_cmd_seq`

## Requirements
- R1: After power-on default, the flag is clear. With no strobe, `cmd_o` and `pass_o` are 0. A strobe to a non-command address gives `pass_o`=1 and `cmd_o`=0.
- R2: In a strobe cycle that matches the next expected step, `cmd_o`=1 and `pass_o`=0. The enable steps are data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. All 15 address bits are compared.
- R3: When the flag is set, a strobe outside an unlocked window that is not a command step gives `cmd_o`=0 and `pass_o`=0.
- R4: A window that closes with no passed byte, but with a blocked byte or a completed sequence, produces exactly one one-cycle pulse on `dummy_o`. A window in which any byte passed produces no pulse.
- R5: After a complete enable sequence, every further strobe in the same window passes, even when the flag is set.
- R6: The disable sequence is 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. Its bytes are flagged as commands, and the flag clears at the end of the next write period.
- R7: A completed sequence changes the flag only on a `cycle_done_i` pulse after its window has closed. Until then the previous protect state governs strobes.
- R8: A strobe that does not match the expected next step returns the detector to idle. That strobe is treated as data under the current flag: it passes when the flag is clear and is blocked when the flag is set.
- R9: If `GAP_CYCLES` cycles pass with no strobe during a partial sequence, the sequence is aborted. A later final step is then handled as data, and the aborted prefix alone requests no dummy cycle.
- R10: `rst_ni` does not clear the flag. Only `por_ni` low clears it.
- R11: Data that is not a command step, written to a command address, is ordinary data: it passes when the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the sequencer and window |
| por_ni | input | 1 | Active-low power-on default for the protect flag only |
| wr_stb_i | input | 1 | Qualified write strobe, one cycle per byte |
| addr_i | input | 15 | Byte address |
| data_i | input | 8 | Byte data |
| cycle_done_i | input | 1 | Pulse at the end of a timed write cycle |
| cmd_o | output | 1 | Strobe is a command byte and must not be stored |
| pass_o | output | 1 | Strobe is a data byte that may enter the page buffer |
| dummy_o | output | 1 | Request a timed cycle that stores nothing |

## Verification
A wrong sequencer state shows up in the strobe cycle itself: a correct next step that is not flagged as a command, or a mismatched byte that is swallowed instead of passing or being blocked. A wrong window state shows up `GAP_CYCLES` cycles after the last strobe, as a missing, doubled or spurious `dummy_o` pulse. An error in the armed or applied flag is only visible after the following `cycle_done_i` pulse, on the next plain data strobe. The bench therefore probes with a data strobe after every write period.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_D3,
    ST_D4,
    ST_D5,
    ST_OPEN
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_SET,
    OP_CLR
  } prot_op_e;
endpackage

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm import wp_pkg::*; #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_A = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] B_UNLK1 = 8'hAA,
  parameter logic [DATA_W-1:0] B_UNLK2 = 8'h55,
  parameter logic [DATA_W-1:0] B_SET = 8'hA0,
  parameter logic [DATA_W-1:0] B_EXT = 8'h80,
  parameter logic [DATA_W-1:0] B_CLR = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              prot_i,
  input  logic              abort_i,
  output logic              cmd_o,
  output logic              pass_o,
  output logic              set_o,
  output logic              clr_o
);
  seq_state_e state_q, state_d;
  logic at_a, at_b, hit;

  assign at_a = (addr_i == KEY_A);
  assign at_b = (addr_i == KEY_B);

  always_comb begin
    state_d = state_q;
    hit     = 1'b0;
    set_o   = 1'b0;
    clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (at_a && data_i == B_UNLK1) begin hit = 1'b1; state_d = ST_K1; end
      ST_K1:   if (at_b && data_i == B_UNLK2) begin hit = 1'b1; state_d = ST_K2; end
      ST_K2: begin
        if (at_a && data_i == B_SET) begin
          hit = 1'b1; set_o = stb_i; state_d = ST_OPEN;
        end else if (at_a && data_i == B_EXT) begin
          hit = 1'b1; state_d = ST_D3;
        end
      end
      ST_D3:   if (at_a && data_i == B_UNLK1) begin hit = 1'b1; state_d = ST_D4; end
      ST_D4:   if (at_b && data_i == B_UNLK2) begin hit = 1'b1; state_d = ST_D5; end
      ST_D5: begin
        if (at_a && data_i == B_CLR) begin
          hit = 1'b1; clr_o = stb_i; state_d = ST_OPEN;
        end
      end
      ST_OPEN: state_d = ST_OPEN;
      default: state_d = ST_IDLE;
    endcase
    // a mismatch drops back to idle; that byte is plain data
    if (state_q != ST_OPEN && !hit) state_d = ST_IDLE;
  end

  always_comb begin
    cmd_o  = 1'b0;
    pass_o = 1'b0;
    if (stb_i) begin
      if (state_q == ST_OPEN) pass_o = 1'b1;
      else if (hit)           cmd_o  = 1'b1;
      else                    pass_o = !prot_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= ST_IDLE;
    else if (abort_i) state_q <= ST_IDLE;
    else if (stb_i)   state_q <= state_d;
  end

  p_cmd_pass_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_o && pass_o));
  p_abort_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE));
  p_open_passes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && state_q == ST_OPEN) |-> (pass_o && !cmd_o));
  p_unprot_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !prot_i && !at_a && !at_b) |-> pass_o);
endmodule

// File: rtl/wp_load_window.sv
module wp_load_window #(
  parameter int unsigned GAP_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic pass_i,
  input  logic cmd_i,
  input  logic seq_i,
  output logic close_o,
  output logic dummy_o
);
  localparam int unsigned CNT_W = $clog2(GAP_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic act_q, any_pass_q, any_blk_q, any_seq_q, dummy_q;

  assign close_o = act_q && !stb_i && (cnt_q == CNT_W'(GAP_CYCLES - 1));
  assign dummy_o = dummy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      act_q      <= 1'b0;
      any_pass_q <= 1'b0;
      any_blk_q  <= 1'b0;
      any_seq_q  <= 1'b0;
      dummy_q    <= 1'b0;
    end else begin
      dummy_q <= 1'b0;
      if (stb_i) begin
        cnt_q      <= '0;
        act_q      <= 1'b1;
        any_pass_q <= any_pass_q | pass_i;
        any_blk_q  <= any_blk_q | (!pass_i && !cmd_i);
        any_seq_q  <= any_seq_q | seq_i;
      end else if (close_o) begin
        act_q      <= 1'b0;
        cnt_q      <= '0;
        dummy_q    <= !any_pass_q && (any_blk_q || any_seq_q);
        any_pass_q <= 1'b0;
        any_blk_q  <= 1'b0;
        any_seq_q  <= 1'b0;
      end else if (act_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_dummy_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_q |=> !dummy_q);
  p_stb_opens_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> (act_q && cnt_q == '0));
  p_no_dummy_on_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && pass_i) |=> !dummy_q);
endmodule

// File: rtl/wp_prot_flag.sv
module wp_prot_flag import wp_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic close_i,
  input  logic done_i,
  output logic prot_o
);
  prot_op_e pend_q, armed_q;
  logic prot_q;

  assign prot_o = prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= OP_NONE;
      armed_q <= OP_NONE;
    end else begin
      if (set_i)      pend_q <= OP_SET;
      else if (clr_i) pend_q <= OP_CLR;
      else if (close_i) pend_q <= OP_NONE;
      if (close_i && pend_q != OP_NONE) armed_q <= pend_q;
      else if (done_i)                  armed_q <= OP_NONE;
    end
  end

  // persistent flag: power-on default only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) prot_q <= 1'b0;
    else if (done_i && armed_q == OP_SET) prot_q <= 1'b1;
    else if (done_i && armed_q == OP_CLR) prot_q <= 1'b0;
  end

  p_flag_hold_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
    !done_i |=> $stable(prot_q));
  p_flag_rst_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rst_ni |=> $stable(prot_q));
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq import wp_pkg::*; #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GAP_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cycle_done_i,
  output logic              cmd_o,
  output logic              pass_o,
  output logic              dummy_o
);
  logic prot, close, seq_set, seq_clr;

  wp_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (wr_stb_i),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .prot_i  (prot),
    .abort_i (close),
    .cmd_o   (cmd_o),
    .pass_o  (pass_o),
    .set_o   (seq_set),
    .clr_o   (seq_clr)
  );

  wp_load_window #(.GAP_CYCLES(GAP_CYCLES)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (wr_stb_i),
    .pass_i  (pass_o),
    .cmd_i   (cmd_o),
    .seq_i   (seq_set | seq_clr),
    .close_o (close),
    .dummy_o (dummy_o)
  );

  wp_prot_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .por_ni  (por_ni),
    .set_i   (seq_set),
    .clr_i   (seq_clr),
    .close_i (close),
    .done_i  (cycle_done_i),
    .prot_o  (prot)
  );

  p_quiet_no_stb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |-> (!cmd_o && !pass_o));
endmodule

// File: tb/tb_wp_cmd_seq.sv
`timescale 1ns/1ps
module tb_wp_cmd_seq;
  localparam int GAP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0, stb = 1'b0, done = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  data = '0;
  logic cmd, pass, dummy;
  int checks = 0, fails = 0, dcnt = 0, dexp = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wp_cmd_seq #(.GAP_CYCLES(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .wr_stb_i(stb),
    .addr_i(addr), .data_i(data), .cycle_done_i(done),
    .cmd_o(cmd), .pass_o(pass), .dummy_o(dummy)
  );

  always @(posedge clk) if (dummy) dcnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d,
                    input bit ecmd, input bit epass, input string tag);
    @(negedge clk);
    stb = 1'b1; addr = a; data = d;
    #1;
    chk({tag, " cmd"}, int'(cmd), int'(ecmd));
    chk({tag, " pass"}, int'(pass), int'(epass));
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic close_win(input int inc, input string tag);
    repeat (GAP + 4) @(negedge clk);
    dexp += inc;
    chk({tag, " dummy count"}, dcnt, dexp);
  endtask

  task automatic period();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic do_enable(input string tag);
    wr(15'h5555, 8'hAA, 1, 0, tag);
    wr(15'h2AAA, 8'h55, 1, 0, tag);
    wr(15'h5555, 8'hA0, 1, 0, tag);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 idle cmd", int'(cmd), 0);
    chk("R1 idle pass", int'(pass), 0);
    chk("R1 idle dummy", int'(dummy), 0);
    wr(15'h0100, 8'h5A, 0, 1, "R1 data");
    close_win(0, "R1"); period();
  endtask

  task automatic t_key_addr_data();
    wr(15'h5555, 8'h33, 0, 1, "R11 key addr data");
    close_win(0, "R11"); period();
  endtask

  task automatic t_enable();
    do_enable("R2 enable");
    close_win(1, "R4 seq only");
    wr(15'h0200, 8'h11, 0, 1, "R7 before period");
    close_win(0, "R7");
    period();
  endtask

  task automatic t_blocked();
    wr(15'h0300, 8'h22, 0, 0, "R3 blocked");
    close_win(1, "R4 blocked");
    period();
  endtask

  task automatic t_unlocked_write();
    do_enable("R5 prefix");
    wr(15'h0300, 8'h44, 0, 1, "R5 data0");
    wr(15'h0301, 8'h45, 0, 1, "R5 data1");
    close_win(0, "R5"); period();
  endtask

  task automatic t_mismatch_prot();
    wr(15'h5555, 8'hAA, 1, 0, "R8 step1");
    wr(15'h0100, 8'h12, 0, 0, "R8 mismatch protected");
    close_win(1, "R8"); period();
  endtask

  task automatic t_timeout();
    wr(15'h5555, 8'hAA, 1, 0, "R9 step1");
    wr(15'h2AAA, 8'h55, 1, 0, "R9 step2");
    close_win(0, "R9 aborted prefix");
    wr(15'h5555, 8'hA0, 0, 0, "R9 late step3");
    close_win(1, "R9"); period();
  endtask

  task automatic t_sync_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr(15'h0400, 8'h66, 0, 0, "R10 after rst_ni");
    close_win(1, "R10"); period();
  endtask

  task automatic t_disable();
    wr(15'h5555, 8'hAA, 1, 0, "R6 d1");
    wr(15'h2AAA, 8'h55, 1, 0, "R6 d2");
    wr(15'h5555, 8'h80, 1, 0, "R6 d3");
    wr(15'h5555, 8'hAA, 1, 0, "R6 d4");
    wr(15'h2AAA, 8'h55, 1, 0, "R6 d5");
    wr(15'h5555, 8'h20, 1, 0, "R6 d6");
    wr(15'h0500, 8'h77, 0, 1, "R6 data after");
    close_win(0, "R6"); period();
    wr(15'h0501, 8'h78, 0, 1, "R6 unprotected");
    close_win(0, "R6 plain"); period();
  endtask

  task automatic t_mismatch_unprot();
    wr(15'h5555, 8'hAA, 1, 0, "R8 step1 u");
    wr(15'h0102, 8'h13, 0, 1, "R8 mismatch unprotected");
    close_win(0, "R8 u"); period();
  endtask

  task automatic t_por();
    do_enable("R10 re-enable");
    close_win(1, "R10 seq"); period();
    wr(15'h0600, 8'h01, 0, 0, "R10 protected again");
    close_win(1, "R10 blk"); period();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    wr(15'h0600, 8'h02, 0, 1, "R10 after por_ni");
    close_win(0, "R10 por"); period();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    t_reset();
    t_key_addr_data();
    t_enable();
    t_blocked();
    t_unlocked_write();
    t_mismatch_prot();
    t_timeout();
    t_sync_reset();
    t_disable();
    t_mismatch_unprot();
    t_por();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule